// File: doc/BRIEF.md
# Twin-Copy Cross-Voting Bit-Flip LDPC Decoder

This block decodes a 16-bit LDPC codeword that reached the receiver twice. Both copies carry the same message and parity bits, produced by one fixed code. Each copy goes into its own component decoder, and the two decoders are identical. On each super iteration, both decoders first run one hard-decision bit-flipping pass in the same cycle. Each then works out which of its bits it would flip. In a second step, those flip proposals are exchanged. A bit is flipped in both decoders only when both decoders proposed it. Otherwise the bit keeps its value in both.

Decoding stops in either of two cases. The first is that one of the decoders holds a word with an all-zero syndrome; the output is then that word, and decoder A wins a tie. The second is that a parameter limit on super iterations is used up. The output is then decoder A's current word, with the converged flag low.

The control is a five-state machine:
- `ST_IDLE`: waits for `start`, then captures both received words.
- `ST_CHECK`: tests both syndromes and the iteration limit. It moves to `ST_REPORT` when it finishes, and to `ST_LOCAL` otherwise.
- `ST_LOCAL`: registers the flip proposals of both decoders, then goes to `ST_CROSS`.
- `ST_CROSS`: applies the agreed flips, counts one super iteration and returns to `ST_CHECK`.
- `ST_REPORT`: raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `ldpc_dual_xdec`

## Requirements
- R1: While reset is held and after its release, `done`, `converged`, `codeword` and `iters` are all zero.
- R2: Column j of the parity-check matrix (codeword bit j) feeds these checks: c0{0,1,2} c1{3,4,5} c2{0,6,7} c3{1,3,6} c4{2,4,7} c5{0,3,5} c6{1,4,6} c7{2,5,7} c8{0,4,6} c9{1,5,7} c10{2,3} c11{4,7} c12{5,6} c13{0,7} c14{1,2} c15{3,6}. A word is valid when every check has even parity over its bits. A valid copy A at start reports converged with 0 iterations.
- R3: In a local pass, each decoder proposes to flip every bit whose number of failing checks, multiplied by 2, exceeds that column's weight.
- R4: The cross step toggles a bit in both decoders exactly when both decoders proposed that bit. The XOR of the two held words therefore never changes.
- R5: Decoding ends at the first check in which either decoder's word is valid. The output comes from the valid decoder, with A chosen when both are valid, and `converged` is 1.
- R6: If neither word is valid after MAX_SUPER (default 8) super iterations, the result is decoder A's word with `converged`=0 and `iters`=MAX_SUPER.
- R7: `iters` reports the number of completed cross steps at the moment of the decision.
- R8: `done` is high for exactly one cycle, 1+3*iters clock edges after the edge that samples `start`. The results hold until the next decode finishes.
- R9: The received words are captured only at the edge where `start` is sampled in `ST_IDLE`. A `start` pulse or input change during a decode has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a decode (sampled in idle) |
| rx_a | input | 16 | hard decisions of first copy |
| rx_b | input | 16 | hard decisions of second copy |
| done | output | 1 | one-cycle result strobe |
| converged | output | 1 | a valid codeword was reached |
| codeword | output | 16 | decoded word |
| iters | output | 4 | super iterations used |

## Verification
The hardest outcome to reach from the ports is the give-up path, where neither decoder ever becomes valid. This only happens when the two copies' flip proposals never agree. The stimulus reaches it with copies that hold different single errors on the all-zero codeword: each decoder then proposes flips the other rejects. The same long decode also carries mid-run `start` pulses and changed inputs, which exercise R9. A wide pseudo-random sweep and every single-bit error pattern are compared against an arithmetic model of the voting rule.

// File: rtl/ldpc_dual_pkg.sv
package ldpc_dual_pkg;
    localparam int unsigned CW_BITS  = 16;
    localparam int unsigned CHK_ROWS = 8;

    typedef logic [CHK_ROWS-1:0] colmask_t;

    // Per-column check membership, bit r set = check r covers this column.
    localparam colmask_t COL_CHK [CW_BITS] = '{
        8'h07, 8'h38, 8'hC1, 8'h4A, 8'h94, 8'h29, 8'h52, 8'hA4,
        8'h51, 8'hA2, 8'h0C, 8'h90, 8'h60, 8'h81, 8'h06, 8'h48
    };

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LOCAL,
        ST_CROSS,
        ST_REPORT
    } xdec_state_t;
endpackage

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome
    import ldpc_dual_pkg::*;
#(
    parameter int unsigned N = CW_BITS,
    parameter int unsigned M = CHK_ROWS
) (
    input  logic [N-1:0] word_i,
    output logic [M-1:0] syn_o
);
    always_comb begin
        syn_o = '0;
        for (int j = 0; j < int'(N); j++) begin
            if (word_i[j]) begin
                syn_o = syn_o ^ M'(COL_CHK[j]);
            end
        end
    end
endmodule

// File: rtl/ldpc_flip_vote.sv
module ldpc_flip_vote
    import ldpc_dual_pkg::*;
#(
    parameter int unsigned N = CW_BITS,
    parameter int unsigned M = CHK_ROWS
) (
    input  logic [M-1:0] syn_i,
    output logic [N-1:0] flip_o
);
    // Majority rule: failing checks strictly above half the column weight.
    always_comb begin
        for (int j = 0; j < int'(N); j++) begin
            flip_o[j] = (2 * $countones(syn_i & M'(COL_CHK[j]))) > $countones(COL_CHK[j]);
        end
    end
endmodule

// File: rtl/ldpc_dual_xdec.sv
module ldpc_dual_xdec
    import ldpc_dual_pkg::*;
#(
    parameter int unsigned MAX_SUPER = 8,
    parameter int unsigned N         = CW_BITS,
    parameter int unsigned M         = CHK_ROWS,
    localparam int unsigned IW       = $clog2(MAX_SUPER + 1),
    localparam int unsigned NDEC     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  rx_a,
    input  logic [N-1:0]  rx_b,
    output logic          done,
    output logic          converged,
    output logic [N-1:0]  codeword,
    output logic [IW-1:0] iters
);
    xdec_state_t   state_q, state_d;
    logic [N-1:0]  word_q [NDEC];
    logic [N-1:0]  flip_w [NDEC];
    logic [N-1:0]  flip_q [NDEC];
    logic [M-1:0]  syn    [NDEC];
    logic [NDEC-1:0] valid;
    logic [IW-1:0] iter_q;
    logic [N-1:0]  agree;
    logic          last_iter;
    logic          finish;

    // Observation points for the bound checker.
    logic          in_cross;
    logic [N-1:0]  word_a;
    logic [N-1:0]  word_b;

    for (genvar g = 0; g < int'(NDEC); g++) begin : g_dec
        ldpc_syndrome #(.N(N), .M(M)) u_syn (
            .word_i (word_q[g]),
            .syn_o  (syn[g])
        );
        ldpc_flip_vote #(.N(N), .M(M)) u_flip (
            .syn_i  (syn[g]),
            .flip_o (flip_w[g])
        );
        assign valid[g] = (syn[g] == '0);
    end

    assign agree     = flip_q[0] & flip_q[1];
    assign last_iter = (iter_q == IW'(MAX_SUPER));
    assign finish    = (|valid) | last_iter;

    assign in_cross = (state_q == ST_CROSS);
    assign word_a   = word_q[0];
    assign word_b   = word_q[1];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = finish ? ST_REPORT : ST_LOCAL;
            ST_LOCAL:  state_d = ST_CROSS;
            ST_CROSS:  state_d = ST_CHECK;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Working words, flip proposals and iteration counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < int'(NDEC); g++) begin
                word_q[g] <= '0;
                flip_q[g] <= '0;
            end
            iter_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        word_q[0] <= rx_a;
                        word_q[1] <= rx_b;
                        iter_q    <= '0;
                    end
                end
                ST_LOCAL: begin
                    for (int g = 0; g < int'(NDEC); g++) begin
                        flip_q[g] <= flip_w[g];
                    end
                end
                ST_CROSS: begin
                    for (int g = 0; g < int'(NDEC); g++) begin
                        word_q[g] <= word_q[g] ^ agree;
                    end
                    iter_q <= iter_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Result registers, loaded on the deciding check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codeword  <= '0;
            converged <= 1'b0;
            iters     <= '0;
        end else if (state_q == ST_CHECK && finish) begin
            codeword  <= valid[0] ? word_q[0] : (valid[1] ? word_q[1] : word_q[0]);
            converged <= |valid;
            iters     <= iter_q;
        end
    end

    // Strobe output
    always_comb begin
        done = (state_q == ST_REPORT);
    end
endmodule

// File: rtl/ldpc_dual_xdec_chk.sv
module ldpc_dual_xdec_chk
    import ldpc_dual_pkg::*;
#(
    parameter int unsigned MAX_SUPER = 8,
    parameter int unsigned N         = CW_BITS,
    parameter int unsigned IW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          converged,
    input logic [N-1:0]  codeword,
    input logic [IW-1:0] iters,
    input logic          in_cross,
    input logic [N-1:0]  word_a,
    input logic [N-1:0]  word_b
);
    function automatic logic [CHK_ROWS-1:0] parity_of(input logic [N-1:0] w);
        logic [CHK_ROWS-1:0] s;
        s = '0;
        for (int j = 0; j < int'(N); j++) begin
            if (w[j]) s = s ^ COL_CHK[j];
        end
        return s;
    endfunction

    // R8: strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a converged result satisfies every check
    a_r5_conv_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (done && converged) |-> (parity_of(codeword) == '0));

    // R6: giving up happens only at the limit
    a_r6_giveup_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !converged) |-> (iters == IW'(MAX_SUPER)));

    // R7: reported count never exceeds the limit
    a_r7_iters_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (iters <= IW'(MAX_SUPER)));

    // R4: joint flips keep the difference between copies
    a_r4_cross_keeps_diff: assert property (@(posedge clk) disable iff (!rst_n)
        in_cross |=> ((word_a ^ word_b) == $past(word_a ^ word_b)));
endmodule

bind ldpc_dual_xdec ldpc_dual_xdec_chk #(
    .MAX_SUPER (MAX_SUPER),
    .N         (N),
    .IW        (IW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .converged (converged),
    .codeword  (codeword),
    .iters     (iters),
    .in_cross  (in_cross),
    .word_a    (word_a),
    .word_b    (word_b)
);

// File: tb/sim_ldpc_dual_xdec.sv
module sim_ldpc_dual_xdec;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS       = 8;
    localparam int IWB        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] rx_a = '0;
    logic [15:0] rx_b = '0;
    logic        done;
    logic        converged;
    logic [15:0] codeword;
    logic [IWB-1:0] iters;

    int n_checks = 0;
    int n_fail   = 0;

    // Check sets per column, taken from R2 (bit r = check r).
    logic [7:0] hcol [16] = '{
        8'h07, 8'h38, 8'hC1, 8'h4A, 8'h94, 8'h29, 8'h52, 8'hA4,
        8'h51, 8'hA2, 8'h0C, 8'h90, 8'h60, 8'h81, 8'h06, 8'h48
    };

    logic [15:0] cws [4];
    int          n_cw = 0;

    ldpc_dual_xdec #(.MAX_SUPER(MAXS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_a(rx_a), .rx_b(rx_b),
        .done(done), .converged(converged), .codeword(codeword), .iters(iters)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bsyn(input logic [15:0] w);
        logic [7:0] s = '0;
        for (int j = 0; j < 16; j++) if (w[j]) s ^= hcol[j];
        return s;
    endfunction

    function automatic logic [15:0] bflip(input logic [15:0] w);
        logic [15:0] f;
        logic [7:0]  s;
        s = bsyn(w);
        for (int j = 0; j < 16; j++)
            f[j] = (2 * $countones(hcol[j] & s)) > $countones(hcol[j]);
        return f;
    endfunction

    function automatic void model(input logic [15:0] a0, input logic [15:0] b0,
                                  output logic [15:0] w, output bit c, output int it);
        logic [15:0] a, b, m;
        a = a0; b = b0; w = a0; c = 1'b0; it = 0;
        for (int k = 0; k <= MAXS; k++) begin
            it = k;
            if (bsyn(a) == 8'h00) begin w = a; c = 1'b1; return; end
            if (bsyn(b) == 8'h00) begin w = b; c = 1'b1; return; end
            if (k == MAXS) begin w = a; c = 1'b0; return; end
            m = bflip(a) & bflip(b);
            a ^= m;
            b ^= m;
        end
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] a, input logic [15:0] b, input bit poke,
                       input string req);
        logic [15:0] ew;
        bit          ec;
        int          eit;
        int          lat;
        bit          seen;
        model(a, b, ew, ec, eit);
        @(negedge clk);
        rx_a = a; rx_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        rx_a = ~a; rx_b = ~b;
        lat = 0;
        seen = 1'b0;
        for (int t = 0; t < 60; t++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (done) begin seen = 1'b1; break; end
            if (poke && (lat == 1 || lat == 4)) begin
                // R9: stray start with a valid word during a decode
                start = 1'b1;
                rx_a = cws[0]; rx_b = cws[0];
            end
        end
        start = 1'b0;
        check(seen, "R8", "done seen", 32'(seen), 1);
        check(codeword == ew, req, "codeword", 32'(codeword), 32'(ew));
        check(converged == ec, req, "converged", 32'(converged), 32'(ec));
        check(int'(iters) == eit, "R7", "iters", 32'(iters), 32'(eit));
        check(lat == 1 + 3 * eit, "R8", "latency", 32'(lat), 32'(1 + 3 * eit));
        @(posedge clk);
        @(negedge clk);
        check(!done, "R8", "done drop", 32'(done), 0);
        check(codeword == ew, "R8", "hold", 32'(codeword), 32'(ew));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        logic [15:0] ra, rb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && !converged && codeword == 0 && iters == 0, "R1", "reset outputs",
              {done, converged, 14'h0, codeword}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && codeword == 0 && iters == 0, "R1", "after release", 32'(codeword), 0);

        for (int x = 1; x < 65536 && n_cw < 4; x++) begin
            if (bsyn(16'(x)) == 8'h00) begin
                cws[n_cw] = 16'(x);
                n_cw++;
            end
        end
        check(n_cw == 4, "R2", "codewords exist", 32'(n_cw), 4);

        // R2: valid A at start
        run(cws[1], 16'hFFFF, 1'b0, "R2");
        // R5: tie goes to A, B-only valid goes to B
        run(cws[1], cws[2], 1'b0, "R5");
        run(cws[1] ^ 16'h0003, cws[2], 1'b0, "R5");

        // R6 with literal expectations: proposals never agree
        run(16'h0001, 16'h0002, 1'b1, "R6");
        check(codeword == 16'h0001 && !converged && iters == 4'd8, "R6", "give up literal",
              32'(codeword), 32'h0001);

        // R3/R4: every single-bit error pattern
        for (int j = 0; j < 16; j++) begin
            run(cws[0] ^ (16'h1 << j), cws[0] ^ (16'h1 << j), 1'b0, "R3");
            run(cws[3] ^ (16'h1 << j), cws[3] ^ (16'h1 << ((j + 5) % 16)), 1'b0, "R4");
        end

        // R9: mid-decode start on a longer run
        run(16'h0001, 16'h0002, 1'b1, "R9");

        // R5/R6/R7 sweep
        lf = 32'h1234_5678;
        for (int k = 0; k < 180; k++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            ra = cws[k % 4] ^ lf[15:0] & lf[31:16];
            rb = (k % 3 == 0) ? ra : (cws[k % 4] ^ (lf[31:16] & ~lf[15:0] & 16'h0F0F));
            run(ra, rb, (k % 7 == 0), "R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule